// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

The block sends asynchronous serial frames from a one-entry holding register feeding a shift register. Software writes a byte into the holding register. In 9-bit mode the write also carries a ninth bit. As soon as the shift register is free, the hardware moves the holding contents into it. A new byte can then be written while the previous one is still on the line, so frames can go out back to back.

Each frame is sent in this order:
- a low start bit;
- 8 or 9 data bits, least significant first;
- a high stop bit.

Every bit lasts from one pulse of an external bit tick to the next. The block reports two flags:
- a holding-empty flag, which also feeds an optional interrupt;
- a separate shift-empty status.

Dropping the enable abandons any frame in progress, clears the holding register and releases the line.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, `hold_empty`=1, `shift_empty`=1, `txd`=1, `txd_oe`=0 and `hold_irq`=0. While `tx_en` is high and no frame is in flight, `txd` stays high and `txd_oe` is 1.
- R2: A frame consists of the following, with each bit held on `txd` until the next `bit_tick` ends it:
  - a start bit of 0;
  - the data bits, bit 0 first;
  - a stop bit of 1.
- R3: When `wr_nine`=1 at the write, 9 data bits are sent, and the ninth is the `wr_bit9` value sampled at that write. Later changes of `wr_bit9` or `wr_nine` do not alter that frame.
- R4: An accepted write clears `hold_empty` one cycle later. Only a write clears it. It sets again in the cycle the contents move into the shift register.
- R5: With the shift register idle, a write is moved into it on the next clock. In that same cycle `txd` drops to the start bit and `shift_empty` falls.
- R6: If the holding register is full when a stop bit ends, the next frame's start bit follows in the very next cycle, with no idle gap.
- R7: `shift_empty` is 0 from the start bit of a frame through its stop bit. It rises only once the last stop bit ends with nothing pending.
- R8: A write while the holding register is full is ignored. The pending byte is sent unchanged and no extra frame follows.
- R9: When `tx_en` is low, the following hold one cycle later:
  - `txd_oe`=0;
  - any frame is abandoned;
  - the holding register is emptied;
  - writes are ignored.
- R10: After `tx_en` is raised and before any write, `hold_empty` reads 1.
- R11: `hold_irq` equals, one cycle later, `hold_empty` AND `hold_irq_en` AND `tx_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; low resets the datapath and releases the line |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| wr_bit9 | input | 1 | Ninth data bit, sampled with the write |
| wr_nine | input | 1 | Selects 9-bit framing for the byte written |
| hold_irq_en | input | 1 | Interrupt enable for the holding-empty flag |
| hold_empty | output | 1 | Holding register can accept a byte |
| shift_empty | output | 1 | No frame is in flight |
| hold_irq | output | 1 | Holding-empty interrupt request |
| txd | output | 1 | Serial line |
| txd_oe | output | 1 | Output enable for the serial line (0 = high impedance) |

## Verification
The bench forks a writer against a line sampler, so that a second byte lands while the first is still shifting. A design that reloads only from idle would show a one-cycle high gap between the two frames. A design that accepts the third write into a full register would corrupt the pending byte or send an extra frame.

The 9-bit case flips `wr_bit9` and `wr_nine` right after the write. This catches a ninth bit taken live at shift time instead of at load time. Dropping `tx_en` mid-frame and writing while disabled exposes leftover holding contents, which would re-emerge as a frame after re-enable.

// File: rtl/uart_dtx_pkg.sv
package uart_dtx_pkg;

  typedef enum logic [1:0] {
    LN_IDLE  = 2'd0,
    LN_START = 2'd1,
    LN_DATA  = 2'd2,
    LN_STOP  = 2'd3
  } line_state_e;

  function automatic int frame_bits(input logic nine, input int base_w);
    return nine ? base_w + 1 : base_w;
  endfunction

endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              wr_nine,
  input  logic              take,
  output logic              full,
  output logic [DATA_W:0]   out_data,
  output logic              out_nine
);

  logic            full_q;
  logic [DATA_W:0] data_q;
  logic            nine_q;
  logic            accept;

  // a write lands only when the register is empty and the block is enabled
  assign accept = enable && wr_en && !full_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      nine_q <= 1'b0;
    end else if (accept) begin
      data_q <= {wr_bit9, wr_data};
      nine_q <= wr_nine;
    end
  end

  assign full     = full_q;
  assign out_data = data_q;
  assign out_nine = nine_q;

  // R8: a write to a full register leaves the pending contents untouched
  a_r8_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (enable && full_q && wr_en && !take) |=> (full_q && $stable(data_q) && $stable(nine_q)));

  // R4: the register only fills in response to a write strobe
  a_r4_fill_needs_write: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> $past(wr_en));

endmodule

// File: rtl/tx_shift_engine.sv
module tx_shift_engine
  import uart_dtx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            bit_tick,
  input  logic            load_ok,
  input  logic [DATA_W:0] load_data,
  input  logic            load_nine,
  output logic            take,
  output logic            line,
  output logic            idle
);

  localparam int CNT_W = $clog2(DATA_W + 2);

  line_state_e     state_q, state_d;
  logic [DATA_W:0] shreg_q, shreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic            line_q, line_d;
  logic            idle_q;

  // reload from idle, or straight out of a finishing stop bit
  assign take = enable && load_ok &&
                ((state_q == LN_IDLE) || (state_q == LN_STOP && bit_tick));

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    last_d  = last_q;
    unique case (state_q)
      LN_IDLE: begin
        if (take) begin
          state_d = LN_START;
          shreg_d = load_data;
          last_d  = CNT_W'(frame_bits(load_nine, DATA_W) - 1);
        end
      end
      LN_START: begin
        if (bit_tick) begin
          state_d = LN_DATA;
          cnt_d   = '0;
        end
      end
      LN_DATA: begin
        if (bit_tick) begin
          shreg_d = shreg_q >> 1;
          if (cnt_q == last_q) state_d = LN_STOP;
          else                 cnt_d   = cnt_q + 1'b1;
        end
      end
      LN_STOP: begin
        if (bit_tick) begin
          if (take) begin
            state_d = LN_START;
            shreg_d = load_data;
            last_d  = CNT_W'(frame_bits(load_nine, DATA_W) - 1);
          end else begin
            state_d = LN_IDLE;
          end
        end
      end
      default: state_d = LN_IDLE;
    endcase
    case (state_d)
      LN_START: line_d = 1'b0;
      LN_DATA:  line_d = shreg_d[0];
      default:  line_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state_q <= LN_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      last_q  <= CNT_W'(DATA_W - 1);
      line_q  <= 1'b1;
      idle_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
      line_q  <= line_d;
      idle_q  <= (state_d == LN_IDLE);
    end
  end

  assign line = line_q;
  assign idle = idle_q;

  // R5: a new frame always opens with a low start bit
  a_r5_start_low: assert property (@(posedge clk) disable iff (rst)
    $fell(idle_q) |-> !line_q);

  // R1: with no frame in flight the line rests high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    idle_q |-> line_q);

  // R2: between ticks the line level does not move during a frame
  a_r2_hold_bit: assert property (@(posedge clk) disable iff (rst || !enable)
    (!idle_q && !bit_tick && state_q != LN_IDLE) |=> $stable(line_q));

  // R6: a pending byte follows a stop bit with no idle gap
  a_r6_no_gap: assert property (@(posedge clk) disable iff (rst || !enable)
    (state_q == LN_STOP && bit_tick && load_ok) |=> (!line_q && !idle_q));

endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              wr_nine,
  input  logic              hold_irq_en,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              hold_irq,
  output logic              txd,
  output logic              txd_oe
);

  logic            full;
  logic [DATA_W:0] hold_data;
  logic            hold_nine;
  logic            take;
  logic            oe_q;
  logic            irq_q;

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .enable   (tx_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_bit9  (wr_bit9),
    .wr_nine  (wr_nine),
    .take     (take),
    .full     (full),
    .out_data (hold_data),
    .out_nine (hold_nine)
  );

  tx_shift_engine #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .enable    (tx_en),
    .bit_tick  (bit_tick),
    .load_ok   (full),
    .load_data (hold_data),
    .load_nine (hold_nine),
    .take      (take),
    .line      (txd),
    .idle      (shift_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      oe_q  <= tx_en;
      irq_q <= tx_en && hold_irq_en && !full;
    end
  end

  assign hold_empty = !full;
  assign txd_oe     = oe_q;
  assign hold_irq   = irq_q;

  // R9: disabling releases the line and idles the shifter on the next cycle
  a_r9_release: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!txd_oe && shift_empty && hold_empty));

  // R4: holding-empty sets only through a transfer or a disable
  a_r4_empty_source: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_empty) |-> ($past(take) || !$past(tx_en)));

  // R11: the interrupt needs its enable
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (rst)
    hold_irq |-> $past(hold_irq_en));

endmodule

// File: tb/uart_dbuf_tx_test.sv
module uart_dbuf_tx_test;

  localparam int DATA_W   = 8;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0;
  logic wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_bit9 = 1'b0;
  logic wr_nine = 1'b0;
  logic hold_irq_en = 1'b0;
  logic bit_tick;
  logic hold_empty, shift_empty, hold_irq, txd, txd_oe;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;

  always #10 clk = ~clk;

  always @(negedge clk) tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
  assign bit_tick = (tick_cnt == TICK_DIV - 1);

  uart_dbuf_tx #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .bit_tick(bit_tick),
    .wr_en(wr_en), .wr_data(wr_data), .wr_bit9(wr_bit9), .wr_nine(wr_nine),
    .hold_irq_en(hold_irq_en), .hold_empty(hold_empty), .shift_empty(shift_empty),
    .hold_irq(hold_irq), .txd(txd), .txd_oe(txd_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wait_tick();
    while (!bit_tick) @(negedge clk);
  endtask

  task automatic do_write(input logic [DATA_W-1:0] d, input logic b9, input logic nine);
    wr_en = 1'b1; wr_data = d; wr_bit9 = b9; wr_nine = nine;
    @(negedge clk);
    wr_en = 1'b0; wr_bit9 = ~b9; wr_nine = ~nine;
  endtask

  task automatic capture(input int nbits, output logic [8:0] bits, output logic stopb);
    int guard = 0;
    bits = '0;
    while (txd !== 1'b0 && guard < 50) begin
      @(negedge clk); guard++;
    end
    for (int i = 0; i < nbits; i++) begin
      wait_tick(); @(negedge clk); bits[i] = txd;
    end
    wait_tick(); @(negedge clk); stopb = txd;
  endtask

  task automatic t_reset();
    chk(hold_empty == 1'b1, "R1 reset hold_empty", hold_empty, 1);
    chk(shift_empty == 1'b1, "R1 reset shift_empty", shift_empty, 1);
    chk(txd == 1'b1 && txd_oe == 1'b0, "R1 reset line", {txd, txd_oe}, 2'b10);
    chk(hold_irq == 1'b0, "R1 reset irq", hold_irq, 0);
  endtask

  task automatic t_enable();
    tx_en = 1'b1;
    @(negedge clk);
    chk(txd_oe == 1'b1 && txd == 1'b1, "R1 enabled idle line", {txd, txd_oe}, 2'b11);
    chk(hold_empty == 1'b1, "R10 empty after enable", hold_empty, 1);
    hold_irq_en = 1'b1;
    @(negedge clk);
    chk(hold_irq == 1'b1, "R11 irq with enable", hold_irq, 1);
    hold_irq_en = 1'b0;
    @(negedge clk);
    chk(hold_irq == 1'b0, "R11 irq masked", hold_irq, 0);
  endtask

  task automatic t_single();
    logic [8:0] b; logic s;
    do_write(8'hA5, 1'b0, 1'b0);
    chk(hold_empty == 1'b0, "R4 cleared by write", hold_empty, 0);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R4 set on transfer", hold_empty, 1);
    chk(shift_empty == 1'b0 && txd == 1'b0, "R5 start at transfer", {shift_empty, txd}, 0);
    capture(8, b, s);
    chk(b[7:0] == 8'hA5, "R2 lsb first data", b[7:0], 8'hA5);
    chk(s == 1'b1, "R2 stop bit", s, 1);
    chk(shift_empty == 1'b0, "R7 busy during stop", shift_empty, 0);
    wait_tick(); @(negedge clk);
    chk(shift_empty == 1'b1 && txd == 1'b1, "R7 empty after stop", {shift_empty, txd}, 2'b11);
  endtask

  task automatic t_nine();
    logic [8:0] b; logic s;
    do_write(8'h3C, 1'b1, 1'b1);
    capture(9, b, s);
    chk(b == 9'h13C, "R3 ninth bit latched", b, 9'h13C);
    chk(s == 1'b1, "R3 stop after ninth", s, 1);
    wait_tick(); @(negedge clk);
    chk(shift_empty == 1'b1, "R7 idle after 9-bit frame", shift_empty, 1);
  endtask

  task automatic t_back_to_back();
    logic [8:0] ba, bb; logic sa, sb;
    do_write(8'h5A, 1'b0, 1'b0);
    fork
      begin
        capture(8, ba, sa);
        wait_tick(); @(negedge clk);
        chk(txd == 1'b0 && shift_empty == 1'b0, "R6 no idle gap", {txd, shift_empty}, 0);
        capture(8, bb, sb);
      end
      begin
        @(negedge clk);
        do_write(8'hC3, 1'b0, 1'b0);
        chk(hold_empty == 1'b0, "R4 second byte pending", hold_empty, 0);
        do_write(8'hFF, 1'b0, 1'b0);
        chk(hold_empty == 1'b0, "R8 full write no effect", hold_empty, 0);
      end
    join
    chk(ba[7:0] == 8'h5A, "R6 first frame", ba[7:0], 8'h5A);
    chk(bb[7:0] == 8'hC3 && sb == 1'b1, "R8 pending byte intact", bb[7:0], 8'hC3);
    wait_tick(); @(negedge clk);
    repeat (3 * TICK_DIV) @(negedge clk);
    chk(shift_empty == 1'b1 && txd == 1'b1, "R8 no extra frame", {shift_empty, txd}, 2'b11);
  endtask

  task automatic t_disable();
    do_write(8'h81, 1'b0, 1'b0);
    @(negedge clk);
    wait_tick(); @(negedge clk);
    wait_tick(); @(negedge clk);
    chk(shift_empty == 1'b0, "R7 busy mid frame", shift_empty, 0);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd_oe == 1'b0, "R9 line released", txd_oe, 0);
    chk(shift_empty == 1'b1 && hold_empty == 1'b1, "R9 frame abandoned",
        {shift_empty, hold_empty}, 2'b11);
    do_write(8'h42, 1'b0, 1'b0);
    tx_en = 1'b1;
    @(negedge clk);
    chk(hold_empty == 1'b1, "R10 empty after re-enable", hold_empty, 1);
    repeat (3 * TICK_DIV) @(negedge clk);
    chk(shift_empty == 1'b1 && txd == 1'b1 && txd_oe == 1'b1, "R9 disabled write ignored",
        {shift_empty, txd, txd_oe}, 3'b111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_enable();
    t_single();
    t_nine();
    t_back_to_back();
    t_disable();
    finish_run();
  end

endmodule